// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block brings four regulator rails up one after another and takes them down again in the opposite order. A start request latches one of several enable orders. For each rail in that order, the block first waits a per-rail gap time and then raises that rail's enable. It then waits a per-rail ramp time and samples the rail's power-good input. When all four rails pass, a done flag is raised. Rails that have already passed stay under watch until power-down begins.

If any check fails, or if a rail that has already passed loses power-good, all enables drop at once. The block then holds a fault flag and the index of the failing rail until a restart request clears them. Timing is counted in ticks of a tick-enable input, so one design serves any time base. A stop request issued while done is high disables the rails in the reverse of the latched order. Each rail is disabled after its own gap time.

Top module: `rail_seq`

## Requirements
- R1: After reset, every enable is low, done and fault are low, and the fault index is 0.
- R2: The order code is sampled only when start is accepted in the idle state. Later changes to it have no effect on a running sequence. The orders, listed as rail indices from first to last, are:
  - code 0: 0,1,2,3
  - code 1: 3,2,1,0
  - code 2: 1,0,3,2
  - code 3: 2,3,0,1
  - code 4: 0,2,1,3
  - code 5: 3,1,2,0
  - codes 6 and 7: 0,1,2,3
- R3: A sequence step for rail r loads gap_cfg bits [16r+15:16r]. The counter drops by one on each clock where tick is high. The enable for r rises on the edge after the counter reads zero, so with tick always high it rises gap+1 edges after the step begins. With tick held low it never rises while the gap is nonzero.
- R4: After rail r is enabled, the block loads ramp_cfg bits [16r+15:16r], counts it down in the same way, and samples pgood[r] on the edge after the counter reads zero. If the check passes, the next step begins on that same edge.
- R5: done rises on the edge where the fourth rail passes its check. While done is high, all four enables are high. done and fault are never high together.
- R6: A failed check drops all enables and raises fault on the same edge, with fault_rail set to the failing rail. No later rail in the order is enabled.
- R7: While stepping up or while done, a rail that has already passed and loses pgood causes a fault on the next edge. fault_rail gives the lowest such index.
- R8: Fault holds, with all enables low, until restart is high on an edge. Start has no effect while fault is high. Restart returns the block to idle with fault low and fault_rail 0.
- R9: stop while done drops done on the next edge. The rails are then disabled in the reverse of the latched order, each gap_cfg(r)+1 ticked edges after the previous step. The block returns to idle after the last rail is disabled.
- R10: Outside a fault entry, at most one enable changes on any edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| tick | input | 1 | time-base enable for the gap and ramp counters |
| start | input | 1 | begin power-up (honoured in idle) |
| stop | input | 1 | begin power-down (honoured while done) |
| restart | input | 1 | clear a latched fault |
| order_mode | input | 3 | enable-order code |
| gap_cfg | input | 4*CNT_W | per-rail gap time, rail r at bits [CNT_W*r +: CNT_W] |
| ramp_cfg | input | 4*CNT_W | per-rail ramp time, same packing |
| pgood | input | 4 | per-rail power-good |
| rail_en | output | 4 | per-rail enable |
| done | output | 1 | all rails up and good |
| fault | output | 1 | latched fault |
| fault_rail | output | 2 | index of the failing rail |

## Verification
Every order code is run up and down under two sets of gap and ramp values that include zero-length windows. The edge on which each enable rises and falls is checked against sums of the configured times, which separates the permutation from the per-rail timing. While each sequence runs, the order code is changed to show that it is latched. The fault sweep fails each rail in turn under six orders, which shows that the fault edge and index track the failing rail's position. A watch fault with two rails lost shows lowest-index priority. A run with tick held low shows that counting is gated by tick.

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic               stop,
  input  logic               restart,
  input  logic [2:0]         order_mode,
  input  logic [4*CNT_W-1:0] gap_cfg,
  input  logic [4*CNT_W-1:0] ramp_cfg,
  input  logic [3:0]         pgood,
  output logic [3:0]         rail_en,
  output logic               done,
  output logic               fault,
  output logic [1:0]         fault_rail
);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_RAMP, S_UP, S_DOWN, S_FAULT} state_t;

  state_t           state;
  logic [1:0]       step;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       ord_q;
  logic [3:0]       ok_mask;

  function automatic logic [7:0] order_of(input logic [2:0] m);
    case (m)
      3'd1:    return {2'd0, 2'd1, 2'd2, 2'd3};
      3'd2:    return {2'd2, 2'd3, 2'd0, 2'd1};
      3'd3:    return {2'd1, 2'd0, 2'd3, 2'd2};
      3'd4:    return {2'd3, 2'd1, 2'd2, 2'd0};
      3'd5:    return {2'd0, 2'd2, 2'd1, 2'd3};
      default: return {2'd3, 2'd2, 2'd1, 2'd0};
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] gap_of(input logic [1:0] r);
    return gap_cfg[r*CNT_W +: CNT_W];
  endfunction

  function automatic logic [CNT_W-1:0] ramp_of(input logic [1:0] r);
    return ramp_cfg[r*CNT_W +: CNT_W];
  endfunction

  function automatic logic [1:0] low_idx(input logic [3:0] m);
    if (m[0]) return 2'd0;
    if (m[1]) return 2'd1;
    if (m[2]) return 2'd2;
    return 2'd3;
  endfunction

  logic [1:0] pos_nx, pos_pv, cur, nxt, prv, first;
  logic [3:0] mon_fail;
  logic       watching, cnt_zero;

  assign pos_nx   = step + 2'd1;
  assign pos_pv   = step - 2'd1;
  assign cur      = ord_q[{step, 1'b0} +: 2];
  assign nxt      = ord_q[{pos_nx, 1'b0} +: 2];
  assign prv      = ord_q[{pos_pv, 1'b0} +: 2];
  assign first    = order_of(order_mode) & 8'h03;
  assign cnt_zero = (cnt == '0);
  assign watching = (state == S_GAP) || (state == S_RAMP) || (state == S_UP);
  assign mon_fail = watching ? (ok_mask & ~pgood) : 4'b0000;
  assign done     = (state == S_UP);
  assign fault    = (state == S_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      step       <= '0;
      cnt        <= '0;
      ord_q      <= '0;
      ok_mask    <= '0;
      rail_en    <= '0;
      fault_rail <= '0;
    end else if (mon_fail != 4'b0000) begin
      rail_en    <= '0;
      ok_mask    <= '0;
      fault_rail <= low_idx(mon_fail);
      state      <= S_FAULT;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ord_q <= order_of(order_mode);
          step  <= '0;
          cnt   <= gap_of(first);
          state <= S_GAP;
        end
        S_GAP: begin
          if (cnt_zero) begin
            rail_en[cur] <= 1'b1;
            cnt          <= ramp_of(cur);
            state        <= S_RAMP;
          end else if (tick) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_RAMP: begin
          if (cnt_zero) begin
            if (!pgood[cur]) begin
              rail_en    <= '0;
              ok_mask    <= '0;
              fault_rail <= cur;
              state      <= S_FAULT;
            end else begin
              ok_mask[cur] <= 1'b1;
              if (step == 2'd3) begin
                state <= S_UP;
              end else begin
                step  <= pos_nx;
                cnt   <= gap_of(nxt);
                state <= S_GAP;
              end
            end
          end else if (tick) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_UP: if (stop) begin
          step  <= 2'd3;
          cnt   <= gap_of(ord_q[7:6]);
          state <= S_DOWN;
        end
        S_DOWN: begin
          if (cnt_zero) begin
            rail_en[cur] <= 1'b0;
            ok_mask[cur] <= 1'b0;
            if (step == 2'd0) begin
              state <= S_IDLE;
            end else begin
              step <= pos_pv;
              cnt  <= gap_of(prv);
            end
          end else if (tick) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_FAULT: if (restart) begin
          fault_rail <= '0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop,
  input logic       restart,
  input logic [3:0] rail_en,
  input logic       done,
  input logic       fault
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rail_en == 4'b0000) && !done && !fault); // R1

  AST_DONE_ALL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rail_en == 4'b1111)); // R5

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R5

  AST_FAULT_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (rail_en == 4'b0000)); // R6

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !restart) |=> fault); // R8

  AST_STOP_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop) |=> !done); // R9

  AST_ONE_RAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fault || ($countones(rail_en ^ $past(rail_en)) <= 1)); // R10

endmodule

bind rail_seq rail_seq_chk u_chk (.*);

// File: tb/sim_rail_seq.sv
module sim_rail_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        restart = 1'b0;
  logic [2:0]  order_mode = 3'd0;
  logic [63:0] gap_cfg, ramp_cfg;
  logic [3:0]  pgood, rail_en;
  logic        done, fault;
  logic [1:0]  fault_rail;
  logic [3:0]  fail_mask = 4'b0000;
  logic [3:0]  drop_mask = 4'b0000;
  int          gap_v[4];
  int          ramp_v[4];
  int          checks = 0;
  int          errs = 0;
  int          step_viol = 0;
  int          cur_mode = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      gap_cfg[r*16 +: 16]  = 16'(gap_v[r]);
      ramp_cfg[r*16 +: 16] = 16'(ramp_v[r]);
    end
  end

  assign pgood = rail_en & ~fail_mask & ~drop_mask;

  rail_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
    .restart(restart), .order_mode(order_mode), .gap_cfg(gap_cfg),
    .ramp_cfg(ramp_cfg), .pgood(pgood), .rail_en(rail_en), .done(done),
    .fault(fault), .fault_rail(fault_rail)
  );

  logic [3:0] prev_en = 4'b0000;
  always @(negedge clk) begin
    if (rst_n && !fault && ($countones(rail_en ^ prev_en) > 1)) step_viol++;
    prev_en = rail_en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ord_pos(input int mode, input int k);
    case (mode)
      1: return 3 - k;
      2: case (k) 0: return 1; 1: return 0; 2: return 3; default: return 2; endcase
      3: case (k) 0: return 2; 1: return 3; 2: return 0; default: return 1; endcase
      4: case (k) 0: return 0; 1: return 2; 2: return 1; default: return 3; endcase
      5: case (k) 0: return 3; 1: return 1; 2: return 2; default: return 0; endcase
      default: return k;
    endcase
  endfunction

  task automatic set_cfg(input int s);
    for (int r = 0; r < 4; r++) begin
      gap_v[r]  = (r * 3 + s) % 5;
      ramp_v[r] = (r * 2 + 1 + s * 2) % 6;
    end
  endtask

  // R2 R3 R4 R5 R6: run one power-up and compare edge counts
  task automatic power_up(input int mode);
    int rise[4];
    int erise[4];
    int done_t, fault_t, fidx, t, efault, eidx, edone;
    bit stopped;
    cur_mode = mode;
    for (int r = 0; r < 4; r++) begin rise[r] = 0; erise[r] = 0; end
    done_t = 0; fault_t = 0; fidx = -1;
    t = 0; efault = 0; eidx = -1; edone = 0; stopped = 0;
    for (int k = 0; k < 4; k++) begin
      int r;
      if (stopped) continue;
      r = ord_pos(mode, k);
      t += gap_v[r] + 1;
      erise[r] = t;
      t += ramp_v[r] + 1;
      if (fail_mask[r]) begin efault = t; eidx = r; stopped = 1; end
    end
    if (!stopped) edone = t;
    @(negedge clk);
    order_mode = 3'(mode);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    order_mode = 3'((mode + 3) % 8);
    for (int n = 1; n <= 400; n++) begin
      @(posedge clk);
      @(negedge clk);
      for (int r = 0; r < 4; r++) if (rail_en[r] && rise[r] == 0) rise[r] = n;
      if (done && done_t == 0) done_t = n;
      if (fault && fault_t == 0) begin fault_t = n; fidx = int'(fault_rail); end
      if (done_t != 0 || fault_t != 0) break;
    end
    for (int r = 0; r < 4; r++)
      chk($sformatf("R2/R3 mode %0d rail %0d enable edge", mode, r), rise[r], erise[r]);
    chk($sformatf("R4/R5 mode %0d done edge", mode), done_t, edone);
    chk($sformatf("R6 mode %0d fault edge", mode), fault_t, efault);
    if (efault != 0) begin
      chk($sformatf("R6 mode %0d fault index", mode), fidx, eidx);
      chk("R6 rails off after fault", int'(rail_en), 0);
    end
  endtask

  // R9: reverse-order power-down
  task automatic power_down();
    int fall[4];
    int efall[4];
    int t;
    t = 0;
    for (int k = 3; k >= 0; k--) begin
      int r;
      r = ord_pos(cur_mode, k);
      t += gap_v[r] + 1;
      efall[r] = t;
    end
    for (int r = 0; r < 4; r++) fall[r] = 0;
    @(negedge clk);
    stop = 1'b1;
    @(posedge clk);
    #1 stop = 1'b0;
    chk("R9 done low after stop", int'(done), 0);
    for (int n = 1; n <= 400; n++) begin
      @(posedge clk);
      @(negedge clk);
      for (int r = 0; r < 4; r++) if (!rail_en[r] && fall[r] == 0) fall[r] = n;
      if (rail_en == 4'b0000) break;
    end
    for (int r = 0; r < 4; r++)
      chk($sformatf("R9 mode %0d rail %0d disable edge", cur_mode, r), fall[r], efall[r]);
    chk("R9 idle after power-down", int'({done, fault}), 0);
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(posedge clk);
    #1 restart = 1'b0;
    chk("R8 restart clears fault", int'(fault), 0);
    chk("R8 restart clears index", int'(fault_rail), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R1..all act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    set_cfg(0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enables after reset", int'(rail_en), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 fault after reset", int'(fault), 0);
    chk("R1 index after reset", int'(fault_rail), 0);

    for (int s = 0; s < 2; s++) begin
      set_cfg(s);
      for (int m = 0; m < 8; m++) begin
        power_up(m);
        power_down();
      end
    end

    set_cfg(1);
    for (int m = 0; m < 6; m++) begin
      for (int f = 0; f < 4; f++) begin
        fail_mask = 4'(1 << f);
        power_up(m);
        fail_mask = 4'b0000;
        @(negedge clk) start = 1'b1;
        repeat (20) @(posedge clk);
        #1 start = 1'b0;
        chk("R8 start ignored in fault", int'(fault), 1);
        chk("R8 rails stay off in fault", int'(rail_en), 0);
        do_restart();
      end
    end

    power_up(0);
    @(negedge clk) drop_mask = 4'b0110;
    @(posedge clk);
    #1;
    chk("R7 watch fault raised", int'(fault), 1);
    chk("R7 lowest failing index", int'(fault_rail), 1);
    chk("R7 rails off", int'(rail_en), 0);
    drop_mask = 4'b0000;
    do_restart();

    for (int r = 0; r < 4; r++) gap_v[r] = 2;
    @(negedge clk);
    tick = 1'b0;
    order_mode = 3'd0;
    cur_mode = 0;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R3 no enable without tick", int'(rail_en), 0);
    tick = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 gap not yet elapsed", int'(rail_en), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 first rail after ticks", int'(rail_en), 1);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R5 done after tick run", int'(done), 1);
    power_down();

    chk("R10 single rail change per edge", step_viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule